// File: doc/BRIEF.md
# Serial EEPROM Slave on a Two-Wire Bus

This block is a two-wire bus slave that looks like a small serial EEPROM to a bus master. It holds 256 bytes arranged as 8-byte pages, together with an address pointer that keeps its value from one transfer to the next. A master reaches the block with a control byte. That byte holds a fixed device type, three chip-select bits that must equal the board straps, and a direction bit. After the control byte the master either writes a word address and data, or reads bytes starting at the pointer.

Both bus lines are sampled by the system clock through two-stage synchronizers. The block finds START and STOP conditions and edges of the serial clock from these samples. It drives the data line only by pulling it low, through an output enable, and changes that enable only while the serial clock is low. A write with an address and no data just moves the pointer, so a random read is a dummy write followed by a repeated START and a read control byte.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A control byte is acknowledged only if bits 7:4 equal 4'b1010 and bits 3:1 equal `sel_i`. Bit 0 gives the direction: 0 writes and 1 reads.
- R2: If a control byte does not match, the slave does not acknowledge it. It then leaves SDA released and acknowledges nothing until the next START. Memory and pointer stay unchanged.
- R3: In a write transfer the slave acknowledges every complete byte. The first byte after the control byte becomes the pointer, and each later byte is stored at the pointer.
- R4: After each stored byte only pointer bits 2:0 increment. Bits 7:3 stay the same, so a page write that runs past the end of the 8-byte page wraps to the start of that page and overwrites earlier bytes.
- R5: A write control byte and a word address with no data, followed by a repeated START and a read control byte, return the byte stored at that address.
- R6: A read control byte with no address first returns the byte at the current pointer. This is the location after the last byte written or read.
- R7: During a read the pointer advances by one after each byte across the whole 256-byte array, wrapping from 0xFF to 0x00. While the master acknowledges, the slave keeps sending. After a master NACK the slave releases SDA and sends nothing more.
- R8: A START or STOP inside a byte abandons that byte. Nothing is stored, SDA is released, and after a START the next byte is treated as a control byte.
- R9: After reset, SDA is released, the pointer is 0 and every location reads 0x00.
- R10: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sel_i | input | 3 | Chip-select straps compared with control byte bits 3:1 |
| sda_oe_o | output | 1 | When high, pulls the data line low |

## Verification
The properties assume that the master changes SDA only while SCL is low, except when it makes START or STOP. They also assume that each SCL level lasts much longer than the three system clocks of synchronizer and edge-detection delay. The bench master keeps every quarter of a bit at ten system clocks and changes SDA only in the low phase of SCL. It makes START and STOP only with SCL held high and the slave released. Random addresses, lengths and data are confined to legal transfers, and the abort cases break a byte only at SCL-low boundaries.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEVICE_TYPE = 4'b1010;

    // transfer phase of the slave
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } phase_e;

    // meaning of the next received byte
    typedef enum logic [1:0] {
        RX_CTRL,
        RX_WADDR,
        RX_WDATA
    } rxrole_e;

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_ff_q, sda_ff_q;
    logic              scl_prev_q, sda_prev_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff_q   <= '1;
            sda_ff_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_ff_q   <= {scl_ff_q[STAGES-2:0], scl_i};
            sda_ff_q   <= {sda_ff_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_ff_q[STAGES-1];
            sda_prev_q <= sda_ff_q[STAGES-1];
        end
    end

    assign scl_s    = scl_ff_q[STAGES-1];
    assign sda_s    = sda_ff_q[STAGES-1];
    assign scl_rise = scl_s & ~scl_prev_q;
    assign scl_fall = ~scl_s & scl_prev_q;
    // data edges while the clock stays high mark bus conditions
    assign start_ev = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_ev  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/eeprom_byte_store.sv
module eeprom_byte_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '0;
            end
        end else if (we) begin
            cells_q[addr] <= wdata;
        end
    end

    assign rdata = cells_q[addr];

endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eeprom_i2c_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_i,
    output logic       sda_oe_o
);

    localparam int CNT_W = $clog2(BYTE_W) + 1;
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e              phase;
        rxrole_e             role;
        logic [BYTE_W-1:0]   shreg;
        logic [CNT_W-1:0]    bitcnt;
        logic                follow_tx;
        logic                oe;
        logic [ADDR_W-1:0]   ptr;
    } slv_state_t;

    slv_state_t cur_q, nxt_d;

    logic              sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic              mem_we;
    logic [BYTE_W-1:0] mem_rdata, rx_byte;
    logic [ADDR_W-1:0] page_next;
    logic              ctrl_match;
    logic              in_idle;
    logic [ADDR_W-PAGE_W-1:0] ptr_page;

    i2c_bus_sampler #(
        .STAGES(SYNC_STAGES)
    ) i_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (bus_start),
        .stop_ev  (bus_stop)
    );

    eeprom_byte_store #(
        .ADDR_W(ADDR_W),
        .DATA_W(BYTE_W)
    ) i_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (cur_q.ptr),
        .wdata (rx_byte),
        .rdata (mem_rdata)
    );

    assign rx_byte    = {cur_q.shreg[BYTE_W-2:0], sda_s};
    assign ctrl_match = (rx_byte[7:4] == DEVICE_TYPE) && (rx_byte[3:1] == sel_i);
    assign page_next  = {cur_q.ptr[ADDR_W-1:PAGE_W], cur_q.ptr[PAGE_W-1:0] + 1'b1};

    always_comb begin
        nxt_d  = cur_q;
        mem_we = 1'b0;
        if (bus_start) begin
            nxt_d.phase     = ST_RX;
            nxt_d.role      = RX_CTRL;
            nxt_d.bitcnt    = '0;
            nxt_d.oe        = 1'b0;
            nxt_d.follow_tx = 1'b0;
        end else if (bus_stop) begin
            nxt_d.phase = ST_IDLE;
            nxt_d.oe    = 1'b0;
        end else begin
            case (cur_q.phase)
                ST_RX: begin
                    if (scl_rise) begin
                        nxt_d.shreg  = rx_byte;
                        nxt_d.bitcnt = cur_q.bitcnt + 1'b1;
                        if (cur_q.bitcnt == BIT_LAST) begin
                            nxt_d.bitcnt    = '0;
                            nxt_d.phase     = ST_RX_ACK;
                            nxt_d.follow_tx = 1'b0;
                            case (cur_q.role)
                                RX_CTRL: begin
                                    if (ctrl_match) begin
                                        nxt_d.follow_tx = rx_byte[0];
                                        if (!rx_byte[0]) nxt_d.role = RX_WADDR;
                                    end else begin
                                        nxt_d.phase = ST_IDLE;
                                    end
                                end
                                RX_WADDR: begin
                                    nxt_d.ptr  = rx_byte[ADDR_W-1:0];
                                    nxt_d.role = RX_WDATA;
                                end
                                default: begin
                                    mem_we    = 1'b1;
                                    nxt_d.ptr = page_next;
                                end
                            endcase
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        if (!cur_q.oe) begin
                            nxt_d.oe = 1'b1;
                        end else if (cur_q.follow_tx) begin
                            nxt_d.phase  = ST_TX;
                            nxt_d.shreg  = mem_rdata;
                            nxt_d.bitcnt = '0;
                            nxt_d.oe     = ~mem_rdata[BYTE_W-1];
                        end else begin
                            nxt_d.phase = ST_RX;
                            nxt_d.oe    = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (cur_q.bitcnt == BIT_LAST) begin
                            nxt_d.oe        = 1'b0;
                            nxt_d.phase     = ST_TX_ACK;
                            nxt_d.bitcnt    = '0;
                            nxt_d.follow_tx = 1'b0;
                            nxt_d.ptr       = cur_q.ptr + 1'b1;
                        end else begin
                            nxt_d.oe     = ~cur_q.shreg[BYTE_W-2];
                            nxt_d.shreg  = {cur_q.shreg[BYTE_W-2:0], 1'b0};
                            nxt_d.bitcnt = cur_q.bitcnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        nxt_d.follow_tx = ~sda_s;
                    end else if (scl_fall) begin
                        if (cur_q.follow_tx) begin
                            nxt_d.phase  = ST_TX;
                            nxt_d.shreg  = mem_rdata;
                            nxt_d.bitcnt = '0;
                            nxt_d.oe     = ~mem_rdata[BYTE_W-1];
                        end else begin
                            nxt_d.phase = ST_IDLE;
                            nxt_d.oe    = 1'b0;
                        end
                    end
                end
                default: begin
                    nxt_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: ST_IDLE, role: RX_CTRL, shreg: '0, bitcnt: '0,
                       follow_tx: 1'b0, oe: 1'b0, ptr: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sda_oe_o = cur_q.oe;
    assign in_idle  = (cur_q.phase == ST_IDLE);
    assign ptr_page = cur_q.ptr[ADDR_W-1:PAGE_W];

endmodule

module eeprom_i2c_slave_chk #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     scl_i,
    input logic                     sda_oe_o,
    input logic                     in_idle,
    input logic                     stop_ev,
    input logic                     mem_we,
    input logic [ADDR_W-PAGE_W-1:0] ptr_page
);

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R2
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> !sda_oe_o);

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (in_idle && !sda_oe_o));

    // R4
    page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ptr_page == $past(ptr_page)));

endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .in_idle  (in_idle),
    .stop_ev  (bus_stop),
    .mem_we   (mem_we),
    .ptr_page (ptr_page)
);

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe_o;
    logic sda_bus;

    assign sda_bus = ~(m_low | sda_oe_o);

    always #(CLK_PERIOD / 2) clk = ~clk;

    eeprom_i2c_slave i_eeprom_i2c_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sel_i    (SEL),
        .sda_oe_o (sda_oe_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int viol = 0;
    logic oe_prev = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] exp_ptr = 8'h00;

    // R10 monitor
    always @(negedge clk) begin
        if (rst_n && (sda_oe_o != oe_prev) && scl) viol++;
        oe_prev = sda_oe_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic q_wait();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; q_wait();
        scl = 1'b1;   q_wait();
        m_low = 1'b1; q_wait();
        scl = 1'b0;   q_wait();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; q_wait();
        scl = 1'b1;   q_wait();
        m_low = 1'b0; q_wait();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; q_wait();
            scl = 1'b1;    q_wait(); q_wait();
            scl = 1'b0;    q_wait();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_low = 1'b0; q_wait();
        scl = 1'b1;   q_wait();
        ack = !sda_bus; q_wait();
        scl = 1'b0;   q_wait();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            q_wait();
            scl = 1'b1; q_wait();
            b[i] = sda_bus; q_wait();
            scl = 1'b0;
        end
        q_wait();
        m_low = give_ack; q_wait();
        scl = 1'b1; q_wait(); q_wait();
        scl = 1'b0; q_wait();
        m_low = 1'b0;
    endtask

    function automatic logic [7:0] ctrl(input bit rd);
        return {4'b1010, SEL, rd};
    endfunction

    function automatic logic [7:0] page_step(input logic [7:0] p);
        return {p[7:3], p[2:0] + 3'd1};
    endfunction

    task automatic tr_write(input logic [7:0] addr, input int n);
        bit ack;
        logic [7:0] d;
        string tag;
        tag = (n > 1) ? "R4" : "R3";
        bus_start();
        send_byte(ctrl(1'b0), ack); chk(ack, "R1", ack, 1);
        send_byte(addr, ack);       chk(ack, "R3", ack, 1);
        exp_ptr = addr;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            send_byte(d, ack); chk(ack, tag, ack, 1);
            exp_mem[exp_ptr] = d;
            exp_ptr = page_step(exp_ptr);
        end
        bus_stop();
    endtask

    task automatic tr_read(input bit rnd, input logic [7:0] addr, input int n);
        bit ack;
        logic [7:0] b;
        string tag;
        tag = rnd ? "R5" : ((n > 1) ? "R7" : "R6");
        bus_start();
        if (rnd) begin
            send_byte(ctrl(1'b0), ack); chk(ack, "R5", ack, 1);
            send_byte(addr, ack);       chk(ack, "R5", ack, 1);
            exp_ptr = addr;
            bus_start();
        end
        send_byte(ctrl(1'b1), ack); chk(ack, "R1", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, b);
            chk(b == exp_mem[exp_ptr], tag, b, exp_mem[exp_ptr]);
            exp_ptr = exp_ptr + 8'd1;
        end
        chk(sda_oe_o == 1'b0, "R7", sda_oe_o, 0);
        bus_stop();
    endtask

    initial begin
        bit ack;
        logic [7:0] b;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9: released and zeroed after reset
        chk(sda_oe_o == 1'b0, "R9", sda_oe_o, 0);
        bus_start();
        send_byte(ctrl(1'b1), ack); chk(ack, "R1", ack, 1);
        recv_byte(1'b0, b); chk(b == 8'h00, "R9", b, 0);
        exp_ptr = 8'h01;
        bus_stop();

        // byte write, random read back
        tr_write(8'h10, 1);
        tr_read(1'b1, 8'h10, 1);
        // page write running past the page end
        tr_write(8'h1D, 10);
        tr_read(1'b1, 8'h18, 8);

        // R1: wrong device type
        bus_start();
        send_byte({4'b1011, SEL, 1'b0}, ack); chk(!ack, "R1", ack, 0);
        bus_stop();
        // R2: wrong chip select, following bytes ignored
        bus_start();
        send_byte({4'b1010, SEL ^ 3'b001, 1'b0}, ack); chk(!ack, "R2", ack, 0);
        send_byte(8'h33, ack); chk(!ack, "R2", ack, 0);
        send_byte(8'h77, ack); chk(!ack, "R2", ack, 0);
        bus_stop();
        tr_read(1'b0, 8'h00, 1);
        tr_read(1'b1, 8'h33, 1);

        // R7: wrap from 0xFF to 0x00
        tr_write(8'hFF, 1);
        tr_read(1'b1, 8'hFE, 4);

        // R8: STOP inside a data byte
        bus_start();
        send_byte(ctrl(1'b0), ack); chk(ack, "R1", ack, 1);
        send_byte(8'h40, ack);      chk(ack, "R3", ack, 1);
        exp_ptr = 8'h40;
        send_bits(8'hC3, 4);
        bus_stop();
        chk(sda_oe_o == 1'b0, "R8", sda_oe_o, 0);
        bus_start();
        send_byte(ctrl(1'b1), ack); chk(ack, "R8", ack, 1);
        recv_byte(1'b0, b); chk(b == exp_mem[8'h40], "R8", b, exp_mem[8'h40]);
        exp_ptr = 8'h41;
        bus_stop();
        // R8: START inside a byte restarts at the control byte
        bus_start();
        send_byte(ctrl(1'b0), ack); chk(ack, "R1", ack, 1);
        send_bits(8'h5A, 3);
        bus_start();
        send_byte(ctrl(1'b1), ack); chk(ack, "R8", ack, 1);
        recv_byte(1'b0, b); chk(b == exp_mem[exp_ptr], "R8", b, exp_mem[exp_ptr]);
        exp_ptr = exp_ptr + 8'd1;
        bus_stop();

        // constrained random transfers
        for (int t = 0; t < 25; t++) begin
            case ($urandom_range(0, 3))
                0: tr_write(8'($urandom), $urandom_range(1, 12));
                1: tr_read(1'b1, 8'($urandom), $urandom_range(1, 8));
                2: tr_read(1'b0, 8'h00, $urandom_range(1, 8));
                default: tr_write(8'($urandom), 1);
            endcase
        end

        chk(viol == 0, "R10", viol, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule